// File: doc/BRIEF.md
# Serial Slave Port with Flag Handshake

This block is the receiving end of a four-wire synchronous serial link. An external controller supplies the shift clock, an active-low select and the incoming data line. The block returns one byte per select window on its outgoing data line, most significant bit first. The CPU loads that byte through a small synchronous register bus. Each finished byte is copied into a receive buffer and raises a completion flag. The flag can drive an interrupt line.

The completion flag uses a two-step handshake. The CPU reads the status register while the flag is set, then reads the data register. Until the status read, writes to the data register are dropped. A second byte that finishes before the flag is cleared is recorded as an overrun. A data write that lands while a byte is in flight is refused and raises a collision bit. All four clock polarity and phase combinations are supported. The serial inputs pass through two-flop synchronizers into the system clock, which must run at least four times faster than the shift clock.

Two state machines run the block. The shifter has three states:
- SH_IDLE: select high or block disabled.
- SH_WAIT: selected, waiting for the leading edge of a byte.
- SH_SHIFT: bits in flight.

Its transitions are:
- SH_IDLE to SH_WAIT when select falls while the block is enabled.
- SH_WAIT to SH_SHIFT on a leading clock edge.
- SH_SHIFT to SH_WAIT on the eighth sampling edge.
- Any state to SH_IDLE when select rises or the block is disabled.

The clear sequencer has two states, CLR_IDLE and CLR_ARMED:
- CLR_IDLE to CLR_ARMED when the status register is read while the flag, the collision bit or the overrun bit is set.
- CLR_ARMED to CLR_IDLE when the data register is read, which clears all three bits.
- CLR_ARMED to CLR_IDLE when a new byte completes with the flag clear, so a fresh flag needs a fresh status read.

Top module: `spi_slave_regs`

## Requirements
- R1: After reset the control, status and data registers read 0, irq is 0 and spi_miso is 0.
- R2: The byte shifted in on spi_mosi, most significant bit first, is returned by a data register read (address 2) after completion. The mode is set by control bit 3 (clock idle level) and control bit 2 (phase). Phase 0 samples on the leading edge; phase 1 samples on the trailing edge. All four modes are supported.
- R3: A byte written to the data register goes out on spi_miso most significant bit first in the same mode. Zeros shift in behind it, so a byte that is not reloaded goes out as 0x00.
- R4: On the eighth sampling edge, status bit 7 (complete) is set and the received byte is copied into the receive buffer. A data read returns the buffer, not the partly shifted next byte.
- R5: irq is high exactly while status bit 7, control bit 1 (interrupt enable) and control bit 0 (block enable) are all set.
- R6: The complete bit clears only when a status read (address 1) taken while the bit is set is followed by a data read. A data read alone leaves the bit set.
- R7: While the complete bit is set and no status read has yet been taken, a data register write has no effect. After the status read, a write is accepted.
- R8: If a second byte completes while the complete bit is still set, status bit 5 (overrun) is set. The buffer keeps the first byte and the second byte is dropped.
- R9: A data write while a byte is in flight is ignored and sets status bit 6 (collision). A byte is in flight from select low to select high in phase 0, and from the first leading edge to the eighth sampling edge in phase 1.
- R10: If select rises before the eighth sampling edge, the partial byte is dropped, the complete bit is not set, and the next byte is received whole.
- R11: With control bit 0 clear, serial activity sets no status bit and irq stays 0.
- R12: The overrun and collision bits are cleared by the same status-then-data read sequence as the complete bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| spi_sck | input | 1 | Serial shift clock from the controller |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |

## Verification
Serial inputs pass two synchronizer flops and one edge register, so each received bit and the complete flag appear about three to four system cycles after the controller's sampling edge. A new output bit appears the same distance after the shifting edge. The bench holds each half of the shift clock for eight system cycles. It samples spi_miso just before its own sampling edge, and reads status at least eight cycles after the last edge of a byte. Register reads return data in the access cycle, while their side effects (arming and clearing) take hold at the clock edge ending that cycle. The bench therefore checks the result of each handshake step with a separate read after it.

// File: rtl/spis_pkg.sv
package spis_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_WAIT,
        SH_SHIFT
    } sh_state_t;

    typedef enum logic {
        CLR_IDLE,
        CLR_ARMED
    } clr_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CTL_EN   = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_CPHA = 2;
    localparam int CTL_CPOL = 3;

    localparam int ST_DONE = 7;
    localparam int ST_WCOL = 6;
    localparam int ST_OVR  = 5;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spis_shifter.sv
module spis_shifter
    import spis_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          sck_s,
    input  logic          ss_s,
    input  logic          mosi_s,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          miso,
    output logic          done,
    output logic [DW-1:0] rx_word,
    output logic          busy
);

    localparam int CW = $clog2(DW);

    sh_state_t     state_q, state_d;
    logic          sck_d;
    logic [DW-1:0] txsr_q;
    logic [DW-2:0] rxsr_q;
    logic [CW-1:0] cnt_q;
    logic          obit_q;

    logic rise, fall, lead, trail, smp_edge, sft_edge, active, smp_ok, last;

    assign rise     = sck_s & ~sck_d;
    assign fall     = ~sck_s & sck_d;
    assign lead     = cpol ? fall : rise;
    assign trail    = cpol ? rise : fall;
    assign smp_edge = cpha ? trail : lead;
    assign sft_edge = cpha ? lead : trail;
    assign active   = en && !ss_s && (state_q != SH_IDLE);
    assign smp_ok   = active && smp_edge &&
                      ((state_q == SH_SHIFT) || ((state_q == SH_WAIT) && lead));
    assign last     = (cnt_q == CW'(DW - 1));
    assign done     = smp_ok && last;
    assign rx_word  = {rxsr_q, mosi_s};
    assign miso     = cpha ? obit_q : txsr_q[DW-1];
    assign busy     = cpha ? (state_q == SH_SHIFT) : (state_q != SH_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en || ss_s) begin
            state_d = SH_IDLE;
        end else begin
            unique case (state_q)
                SH_IDLE:  state_d = SH_WAIT;
                SH_WAIT:  if (lead) state_d = SH_SHIFT;
                SH_SHIFT: if (smp_ok && last) state_d = SH_WAIT;
                default:  state_d = SH_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            txsr_q <= '0;
            rxsr_q <= '0;
            cnt_q  <= '0;
            obit_q <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (load) begin
                txsr_q <= load_data;
            end else if (active && sft_edge) begin
                obit_q <= txsr_q[DW-1];
                txsr_q <= {txsr_q[DW-2:0], 1'b0};
            end
            if (!active) begin
                cnt_q <= '0;
            end else if (smp_ok) begin
                rxsr_q <= rx_word[DW-2:0];
                cnt_q  <= last ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assert_abort_clears_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> (cnt_q == '0));

    assert_done_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_tx_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sft_edge && !load) |=> (txsr_q[DW-1] == $past(txsr_q[DW-2])));

endmodule

// File: rtl/spis_regif.sv
module spis_regif
    import spis_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          done,
    input  logic [DW-1:0] rx_word,
    input  logic          busy,
    output logic          en,
    output logic          cpol,
    output logic          cpha,
    output logic          load,
    output logic [DW-1:0] load_data,
    output logic          irq
);

    clr_state_t    clr_q, clr_d;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] rxbuf_q;
    logic          flag_q, wcol_q, ovr_q;

    logic stat_rd, data_rd, data_wr, ctrl_wr, clear, blocked, ie;

    assign stat_rd   = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
    assign data_rd   = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
    assign data_wr   = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
    assign ctrl_wr   = bus_sel &&  bus_wr && (bus_addr == ADDR_CTRL);
    assign clear     = (clr_q == CLR_ARMED) && data_rd;
    assign blocked   = flag_q && (clr_q == CLR_IDLE);
    assign load      = data_wr && !busy && !blocked;
    assign load_data = bus_wdata;

    assign en   = ctrl_q[CTL_EN];
    assign ie   = ctrl_q[CTL_IE];
    assign cpha = ctrl_q[CTL_CPHA];
    assign cpol = ctrl_q[CTL_CPOL];
    assign irq  = flag_q && ie && en;

    // clear sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= CLR_IDLE;
        else        clr_q <= clr_d;
    end

    always_comb begin
        clr_d = clr_q;
        unique case (clr_q)
            CLR_IDLE:  if (stat_rd && (flag_q || wcol_q || ovr_q)) clr_d = CLR_ARMED;
            CLR_ARMED: if (data_rd || (done && !flag_q)) clr_d = CLR_IDLE;
            default:   clr_d = CLR_IDLE;
        endcase
    end

    // status, buffer and control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            rxbuf_q <= '0;
            flag_q  <= 1'b0;
            wcol_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata;

            if (done) begin
                if (flag_q && !clear) begin
                    ovr_q <= 1'b1;
                end else begin
                    flag_q  <= 1'b1;
                    rxbuf_q <= rx_word;
                    if (clear) ovr_q <= 1'b0;
                end
            end else if (clear) begin
                flag_q <= 1'b0;
                ovr_q  <= 1'b0;
            end

            if (data_wr && busy) wcol_q <= 1'b1;
            else if (clear)      wcol_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: begin
                bus_rdata[ST_DONE] = flag_q;
                bus_rdata[ST_WCOL] = wcol_q;
                bus_rdata[ST_OVR]  = ovr_q;
            end
            ADDR_DATA: bus_rdata = rxbuf_q;
            default:   bus_rdata = '0;
        endcase
    end

    assert_flag_clear_needs_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(data_rd && (clr_q == CLR_ARMED)));

    assert_overrun_keeps_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_q && !clear) |=> (ovr_q && $stable(rxbuf_q)));

    assert_busy_write_collides_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> wcol_q);

    assert_blocked_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && flag_q && (clr_q == CLR_IDLE)) |-> !load);

    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

endmodule

// File: rtl/spi_slave_regs.sv
module spi_slave_regs
    import spis_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic          spi_sck,
    input  logic          spi_ss_n,
    input  logic          spi_mosi,
    output logic          spi_miso
);

    logic [2:0]    pins_s;
    logic          en, cpol, cpha, load, done, busy;
    logic [DW-1:0] load_data, rx_word;

    spis_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_ss_n, spi_mosi}),
        .q     (pins_s)
    );

    spis_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cpol      (cpol),
        .cpha      (cpha),
        .sck_s     (pins_s[2]),
        .ss_s      (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .load      (load),
        .load_data (load_data),
        .miso      (spi_miso),
        .done      (done),
        .rx_word   (rx_word),
        .busy      (busy)
    );

    spis_regif #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done),
        .rx_word   (rx_word),
        .busy      (busy),
        .en        (en),
        .cpol      (cpol),
        .cpha      (cpha),
        .load      (load),
        .load_data (load_data),
        .irq       (irq)
    );

endmodule

// File: tb/tb_spi_slave_regs.sv
module tb_spi_slave_regs;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       spi_sck = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [1:0] cur_mode = 2'd0;

    always #4 clk = ~clk;

    spi_slave_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .spi_sck(spi_sck), .spi_ss_n(spi_ss_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] stat_val(input bit f, input bit w, input bit o);
        return {f, w, o, 5'b0};
    endfunction

    function automatic logic [7:0] ctrl_val(input bit en, input bit ie, input logic [1:0] mode);
        return {4'b0, mode[1], mode[0], ie, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic set_mode(input logic [1:0] mode, input bit en, input bit ie);
        cur_mode = mode;
        spi_sck = mode[1];
        reg_wr(2'd0, ctrl_val(en, ie, mode));
        wait_cyc(4);
    endtask

    task automatic sel_low();
        @(negedge clk);
        spi_ss_n = 0;
        wait_cyc(HALF);
    endtask

    task automatic sel_high();
        wait_cyc(HALF);
        spi_ss_n = 1;
        wait_cyc(HALF);
    endtask

    task automatic one_bit(input int i, input logic [7:0] mtx, inout logic [7:0] mrx);
        if (!cur_mode[0]) begin
            spi_mosi = mtx[7-i];
            wait_cyc(HALF);
            mrx[7-i] = spi_miso;
            spi_sck = ~cur_mode[1];
            wait_cyc(HALF);
            spi_sck = cur_mode[1];
        end else begin
            wait_cyc(HALF);
            spi_sck = ~cur_mode[1];
            spi_mosi = mtx[7-i];
            wait_cyc(HALF);
            mrx[7-i] = spi_miso;
            spi_sck = cur_mode[1];
        end
    endtask

    task automatic xfer(input logic [7:0] mtx, output logic [7:0] mrx);
        logic [7:0] r = 8'h00;
        sel_low();
        for (int i = 0; i < 8; i++) one_bit(i, mtx, r);
        sel_high();
        mrx = r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, mrx, s, m;
        logic [7:0] part;
        logic [1:0] mode;
        bit ie;
        void'($urandom(32'd20240611));

        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);

        // R1 reset state
        reg_rd(2'd0, rd); chk("R1 ctrl", rd, 8'h00);
        reg_rd(2'd1, rd); chk("R1 status", rd, 8'h00);
        reg_rd(2'd2, rd); chk("R1 data", rd, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 miso", spi_miso, 1'b0);

        // random transfers across all modes (R2, R3, R4, R5, R6)
        for (int n = 0; n < 24; n++) begin
            mode = 2'($urandom % 4);
            ie   = 1'($urandom % 2);
            s    = 8'($urandom);
            m    = 8'($urandom);
            set_mode(mode, 1'b1, ie);
            reg_wr(2'd2, s);
            xfer(m, mrx);
            chk("R3 miso byte", mrx, s);
            chk("R5 irq on complete", irq, ie);
            reg_rd(2'd1, rd); chk("R4 complete set", rd, stat_val(1, 0, 0));
            reg_rd(2'd2, rd); chk("R2 received byte", rd, m);
            reg_rd(2'd1, rd); chk("R6 cleared", rd, stat_val(0, 0, 0));
            chk("R5 irq low", irq, 1'b0);
        end

        // R6: a data read alone does not clear
        set_mode(2'd3, 1'b1, 1'b1);
        reg_wr(2'd2, 8'h05);
        xfer(8'hC4, mrx);
        reg_rd(2'd2, rd); chk("R6 data read alone", rd, 8'hC4);
        reg_rd(2'd1, rd); chk("R6 flag still set", rd, stat_val(1, 0, 0));
        reg_rd(2'd2, rd);
        reg_rd(2'd1, rd); chk("R6 sequence clears", rd, stat_val(0, 0, 0));

        // R7: write blocked while flag set before status read
        set_mode(2'd0, 1'b1, 1'b0);
        reg_wr(2'd2, 8'h3E);
        xfer(8'h00, mrx);
        chk("R3 mode0 out", mrx, 8'h3E);
        reg_wr(2'd2, 8'h5A);
        reg_rd(2'd1, rd); chk("R7 flag set", rd, stat_val(1, 0, 0));
        reg_rd(2'd2, rd);
        xfer(8'h10, mrx);
        chk("R7 blocked write had no effect", mrx, 8'h00);
        reg_rd(2'd1, rd);
        reg_wr(2'd2, 8'hC3);
        reg_rd(2'd2, rd); chk("R7 data", rd, 8'h10);
        xfer(8'h20, mrx);
        chk("R7 write after status read accepted", mrx, 8'hC3);
        reg_rd(2'd1, rd); reg_rd(2'd2, rd);

        // R8 overrun with R4 buffered read mid-byte, R12 clear
        set_mode(2'd2, 1'b1, 1'b0);
        reg_wr(2'd2, 8'hA1);
        xfer(8'hB1, mrx);
        sel_low();
        part = 8'h00;
        for (int i = 0; i < 4; i++) one_bit(i, 8'hB2, part);
        reg_rd(2'd2, rd); chk("R4 buffer not live shift", rd, 8'hB1);
        for (int i = 4; i < 8; i++) one_bit(i, 8'hB2, part);
        sel_high();
        reg_rd(2'd1, rd); chk("R8 overrun status", rd, stat_val(1, 0, 1));
        reg_rd(2'd2, rd); chk("R8 buffer keeps first", rd, 8'hB1);
        reg_rd(2'd1, rd); chk("R12 overrun cleared", rd, stat_val(0, 0, 0));

        // R9 collision, phase 0: write while selected
        set_mode(2'd0, 1'b1, 1'b0);
        reg_wr(2'd2, 8'h11);
        sel_low();
        reg_wr(2'd2, 8'h77);
        reg_rd(2'd1, rd); chk("R9 collision phase0", rd, stat_val(0, 1, 0));
        part = 8'h00;
        for (int i = 0; i < 8; i++) one_bit(i, 8'h4B, part);
        sel_high();
        chk("R9 collided write ignored", part, 8'h11);
        reg_rd(2'd1, rd); chk("R9 status after byte", rd, stat_val(1, 1, 0));
        reg_rd(2'd2, rd); chk("R2 data phase0", rd, 8'h4B);
        reg_rd(2'd1, rd); chk("R12 collision cleared", rd, stat_val(0, 0, 0));

        // R9 collision, phase 1: write between bits
        set_mode(2'd1, 1'b1, 1'b0);
        reg_wr(2'd2, 8'h22);
        sel_low();
        part = 8'h00;
        for (int i = 0; i < 4; i++) one_bit(i, 8'hE7, part);
        reg_wr(2'd2, 8'h99);
        for (int i = 4; i < 8; i++) one_bit(i, 8'hE7, part);
        sel_high();
        chk("R9 phase1 out unchanged", part, 8'h22);
        reg_rd(2'd1, rd); chk("R9 collision phase1", rd, stat_val(1, 1, 0));
        reg_rd(2'd2, rd); chk("R2 data phase1", rd, 8'hE7);

        // R10 abort mid-byte
        reg_wr(2'd2, 8'h3C);
        sel_low();
        part = 8'h00;
        for (int i = 0; i < 4; i++) one_bit(i, 8'hF0, part);
        sel_high();
        reg_rd(2'd1, rd); chk("R10 no flag after abort", rd, stat_val(0, 0, 0));
        chk("R10 irq low", irq, 1'b0);
        xfer(8'h69, mrx);
        reg_rd(2'd1, rd); chk("R10 next byte completes", rd, stat_val(1, 0, 0));
        reg_rd(2'd2, rd); chk("R10 next byte whole", rd, 8'h69);

        // R11 disabled block ignores the link
        set_mode(2'd0, 1'b0, 1'b1);
        xfer(8'hAA, mrx);
        reg_rd(2'd1, rd); chk("R11 no status when disabled", rd, stat_val(0, 0, 0));
        chk("R11 irq low when disabled", irq, 1'b0);
        reg_rd(2'd2, rd); chk("R11 buffer unchanged", rd, 8'h69);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule